// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block takes asynchronous serial characters from one input line. It works from a system clock together with a clock enable that pulses sixteen times per bit period. The line is first brought into the clock domain through a short synchronizer, and an optional inversion is applied. A falling edge starts a character. The start bit is confirmed at its centre, each data bit is decided by a vote of three samples, and the stop bit is checked for framing.

Each finished character goes into a two-entry buffer together with its framing status. The consumer reads the oldest entry from the data and framing outputs and removes it with a one-cycle read strobe. When a character completes while the buffer is full, the character is lost and an overrun flag is raised. The receiver then stays stopped until the overrun is cleared.

Top module: `serial_rx16`

## Requirements
- R1: After reset, `data_avail` and `overrun` are 0.
- R2: A character begins at a high-to-low transition of the (polarity-corrected) line, seen on an oversample tick while idle. On the eighth tick after that edge the line is checked again. If it is high, the attempt is dropped without any output or flag, and the receiver waits for a new falling edge.
- R3: Each data bit and the stop bit take the majority of the samples at ticks 7, 8 and 9 of that bit, counted from 0 at the bit's first tick. A single inverted sample at tick 8 does not change the received value.
- R4: With `nine_bit`=0 a character has 8 data bits, sent least significant bit first, and they appear in `rd_data[7:0]` with `rd_data[8]`=0.
- R5: With `nine_bit`=1 a character has 9 data bits, least significant bit first, and the ninth appears in `rd_data[8]`.
- R6: A stop bit voted low stores `rd_frame_err`=1 with that character. A stop bit voted high stores 0.
- R7: Finished characters enter a two-entry first-in first-out buffer. `data_avail` is 1 while at least one entry is held. `rd_data` and `rd_frame_err` show the oldest entry, and a one-cycle `rd_strobe` removes it. Entries leave only through `rd_strobe`.
- R8: If a character completes while both entries are full and no read happens in that cycle, `overrun` goes to 1, the character is discarded, and no later character is received while `overrun` is 1.
- R9: Driving `rx_enable` low clears `overrun` on the next clock and aborts any character in progress. It leaves the buffered entries untouched.
- R10: With `line_invert`=1 the input is inverted before any other processing, so the idle level is low and the data bits are active low.
- R11: Characters are received only while `rx_enable`=1, `port_enable`=1 and `sync_mode`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| os_tick | input | 1 | Oversample enable, sixteen pulses per bit |
| rx_line | input | 1 | Serial input line |
| rx_enable | input | 1 | Receiver enable; low clears overrun |
| port_enable | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select; receiver idles when 1 |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| line_invert | input | 1 | 1 inverts the input line |
| rd_strobe | input | 1 | Removes the oldest buffered character |
| rd_data | output | 9 | Oldest buffered character |
| rd_frame_err | output | 1 | Framing status of the oldest character |
| data_avail | output | 1 | Buffer holds at least one character |
| overrun | output | 1 | Character lost because the buffer was full |

## Verification
If the tick counter or the bit index is wrong, the fault shows as a wrong `rd_data` value or a wrong framing bit. It appears when the character enters the buffer, about ten bit periods after its start edge. A wrong buffer pointer or count shows up as a reordered or repeated character, or as `data_avail` falling without a strobe, at the next read. A wrong overrun path shows up either as an extra character after the third one, or as `overrun` still set after `rx_enable` has gone low, one clock after the stimulus.

// File: rtl/serial_rx_pkg.sv
// Shared constants and types for the oversampled serial receiver.
// Assumes at most nine data bits per character.
package serial_rx_pkg;
    localparam int DATA_W = 9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic              ferr;
        logic [DATA_W-1:0] data;
    } rx_char_t;
endpackage

// File: rtl/rx_line_sync.sv
// Brings the asynchronous serial input into the clock domain through a
// flop chain. Assumes STAGES >= 2. The chain resets to the idle level (1).
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the input level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_bit_engine.sv
// Per-character state machine. It detects the start edge on an oversample
// tick, confirms the start bit at mid-bit, takes three-sample majority
// votes for the data and stop bits, and emits a one-cycle done pulse with
// the finished character. Assumes OSR >= 4 and a synchronized line input.
module rx_bit_engine
    import serial_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     line,
    input  logic     run,
    input  logic     nine_bit,
    output logic     done,
    output rx_char_t done_char
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DATA_W);
    localparam logic [CW-1:0] T_MID  = CW'(OSR / 2);
    localparam logic [CW-1:0] T_LO   = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] T_HI   = CW'(OSR / 2 + 1);
    localparam logic [CW-1:0] T_LAST = CW'(OSR - 1);

    rx_state_t         state;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     cnt_nxt;
    logic [BW-1:0]     bidx;
    logic [BW-1:0]     last_idx;
    logic [DATA_W-1:0] shreg;
    logic              prev;
    logic              s_lo;
    logic              s_mid;
    logic              vote;

    // Two-of-three vote over the samples at ticks 7, 8 and 9.
    assign vote     = (s_lo & s_mid) | (s_lo & line) | (s_mid & line);
    // Index of the final data bit for the selected length.
    assign last_idx = nine_bit ? BW'(DATA_W - 1) : BW'(DATA_W - 2);
    // Oversample counter with wrap at the end of a bit.
    assign cnt_nxt  = (cnt == T_LAST) ? '0 : cnt + CW'(1);

    // Character reception state machine, advanced on oversample ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            bidx      <= '0;
            shreg     <= '0;
            prev      <= 1'b1;
            s_lo      <= 1'b0;
            s_mid     <= 1'b0;
            done      <= 1'b0;
            done_char <= '0;
        end else begin
            done <= 1'b0;
            if (!run) begin
                state <= ST_IDLE;
                cnt   <= '0;
                prev  <= line;
            end else if (tick) begin
                prev <= line;
                case (state)
                    ST_IDLE: begin
                        if (prev && !line) begin
                            state <= ST_START;
                            cnt   <= CW'(1);
                            bidx  <= '0;
                            shreg <= '0;
                        end
                    end
                    ST_START: begin
                        cnt <= cnt_nxt;
                        if (cnt == T_MID && line) state <= ST_IDLE;
                        else if (cnt == T_LAST)   state <= ST_DATA;
                    end
                    ST_DATA, ST_STOP: begin
                        cnt <= cnt_nxt;
                        if (cnt == T_LO)  s_lo  <= line;
                        if (cnt == T_MID) s_mid <= line;
                        if (cnt == T_HI) begin
                            if (state == ST_DATA) begin
                                shreg[bidx] <= vote;
                            end else begin
                                done           <= 1'b1;
                                done_char.ferr <= ~vote;
                                done_char.data <= shreg;
                                state          <= ST_IDLE;
                            end
                        end
                        if (state == ST_DATA && cnt == T_LAST) begin
                            if (bidx == last_idx) state <= ST_STOP;
                            else                  bidx  <= bidx + BW'(1);
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_char_fifo.sv
// Small first-in first-out buffer for received characters, with the
// framing status stored in each entry. Assumes the caller never pushes
// when full without a pop in the same cycle, and never pops when empty.
module rx_char_fifo
    import serial_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  logic     pop,
    input  rx_char_t din,
    output rx_char_t dout,
    output logic     not_empty,
    output logic     full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] P_LAST = PW'(DEPTH - 1);

    rx_char_t      mem [DEPTH];
    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;
    logic [NW-1:0] count;

    // Storage, pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push) begin
                mem[wptr] <= din;
                wptr      <= (wptr == P_LAST) ? '0 : wptr + PW'(1);
            end
            if (pop) rptr <= (rptr == P_LAST) ? '0 : rptr + PW'(1);
            case ({push, pop})
                2'b10:   count <= count + NW'(1);
                2'b01:   count <= count - NW'(1);
                default: count <= count;
            endcase
        end
    end

    assign dout      = mem[rptr];
    assign not_empty = (count != '0);
    assign full      = (count == NW'(DEPTH));
endmodule

// File: rtl/serial_rx16.sv
// Top of the oversampled asynchronous serial receiver. It applies the
// polarity control, synchronizes the line, runs the bit engine while the
// enables allow it, buffers characters and keeps the overrun flag.
// Assumes os_tick is a one-cycle enable at OSR times the bit rate.
module serial_rx16
    import serial_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int FIFO_DEPTH  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_line,
    input  logic              rx_enable,
    input  logic              port_enable,
    input  logic              sync_mode,
    input  logic              nine_bit,
    input  logic              line_invert,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_frame_err,
    output logic              data_avail,
    output logic              overrun
);
    logic     active;
    logic     run;
    logic     line;
    logic     done;
    logic     push;
    logic     pop;
    logic     full;
    logic     not_empty;
    logic     ovr_q;
    rx_char_t done_char;
    rx_char_t head;

    // Receiver runs only in asynchronous mode with both enables set and no overrun.
    assign active = rx_enable & port_enable & ~sync_mode;
    assign run    = active & ~ovr_q;

    rx_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_line ^ line_invert),
        .dout  (line)
    );

    rx_bit_engine #(.OSR(OSR)) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (os_tick),
        .line      (line),
        .run       (run),
        .nine_bit  (nine_bit),
        .done      (done),
        .done_char (done_char)
    );

    assign pop  = rd_strobe & not_empty;
    assign push = done & (~full | pop);

    rx_char_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .din       (done_char),
        .dout      (head),
        .not_empty (not_empty),
        .full      (full)
    );

    // Overrun flag: set when a character is lost, cleared by receiver disable.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ovr_q <= 1'b0;
        else if (!rx_enable)         ovr_q <= 1'b0;
        else if (done && !push)      ovr_q <= 1'b1;
    end

    assign rd_data      = head.data;
    assign rd_frame_err = head.ferr;
    assign data_avail   = not_empty;
    assign overrun      = ovr_q;
endmodule

// File: rtl/serial_rx16_chk.sv
// Port-level properties of the serial receiver, bound to every instance.
module serial_rx16_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_enable,
    input logic port_enable,
    input logic sync_mode,
    input logic rd_strobe,
    input logic data_avail,
    input logic overrun
);
    // R8
    ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(data_avail));

    // R8
    ovr_blocks_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && $past(overrun)) |-> !$rose(data_avail));

    // R9
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !overrun);

    // R7
    drain_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_avail) |-> $past(rd_strobe));

    // R11
    gated_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_avail) |-> $past(rx_enable && port_enable && !sync_mode));
endmodule

bind serial_rx16 serial_rx16_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_enable   (rx_enable),
    .port_enable (port_enable),
    .sync_mode   (sync_mode),
    .rd_strobe   (rd_strobe),
    .data_avail  (data_avail),
    .overrun     (overrun)
);

// File: tb/test_serial_rx16.sv
module test_serial_rx16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tcnt;
    logic       os_tick;
    logic       rx_line = 1'b1;
    logic       rx_enable = 1'b1;
    logic       port_enable = 1'b1;
    logic       sync_mode = 1'b0;
    logic       nine_bit = 1'b0;
    logic       line_invert = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [8:0] rd_data;
    logic       rd_frame_err;
    logic       data_avail;
    logic       overrun;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    auto_read = 1'b1;
    bit    finished = 1'b0;
    logic [9:0] sb_q [$];
    string      sb_tag [$];

    always #5 clk = ~clk;

    // One oversample tick every four clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) tcnt <= 2'd0;
        else        tcnt <= tcnt + 2'd1;
    end
    assign os_tick = (tcnt == 2'd3);

    serial_rx16 i_serial_rx16 (
        .clk          (clk),
        .rst_n        (rst_n),
        .os_tick      (os_tick),
        .rx_line      (rx_line),
        .rx_enable    (rx_enable),
        .port_enable  (port_enable),
        .sync_mode    (sync_mode),
        .nine_bit     (nine_bit),
        .line_invert  (line_invert),
        .rd_strobe    (rd_strobe),
        .rd_data      (rd_data),
        .rd_frame_err (rd_frame_err),
        .data_avail   (data_avail),
        .overrun      (overrun)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard entry: {frame error, data} as the requirements define them.
    task automatic expect_char(input logic [8:0] d, input logic fe, input string tag);
        sb_q.push_back({fe, nine_bit ? d : {1'b0, d[7:0]}});
        sb_tag.push_back(tag);
    endtask

    // Drive one character, one value per tick period; gbit/gtick flip one sample.
    task automatic send_char(input logic [8:0] d, input logic stop_v, input int gbit, input int gtick);
        int nb;
        nb = nine_bit ? 9 : 8;
        for (int bi = 0; bi < nb + 2; bi++) begin
            for (int t = 0; t < 16; t++) begin
                logic v;
                if (bi == 0)       v = 1'b0;
                else if (bi <= nb) v = d[bi-1];
                else               v = stop_v;
                if (bi == gbit && t == gtick) v = ~v;
                rx_line = v ^ line_invert;
                repeat (4) @(negedge clk);
            end
        end
        rx_line = 1'b1 ^ line_invert;
        repeat (128) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        repeat (20) @(negedge clk);
        check(sb_q.size() == 0, tag, sb_q.size(), 0);
    endtask

    // Monitor: pops the scoreboard and compares each character read out.
    initial begin
        forever begin
            @(negedge clk);
            if (rd_strobe) begin
                rd_strobe = 1'b0;
            end else if (auto_read && rst_n && data_avail) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R7 unexpected character", {22'd0, rd_frame_err, rd_data}, 0);
                end else begin
                    logic [9:0] exp;
                    string      tg;
                    exp = sb_q.pop_front();
                    tg  = sb_tag.pop_front();
                    check({rd_frame_err, rd_data} == exp, tg, {22'd0, rd_frame_err, rd_data}, {22'd0, exp});
                end
                rd_strobe = 1'b1;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset state
        check(data_avail == 1'b0, "R1 data_avail after reset", data_avail, 0);
        check(overrun == 1'b0, "R1 overrun after reset", overrun, 0);
        repeat (64) @(negedge clk);

        // R4: 8-bit characters, several patterns
        expect_char(9'h055, 1'b0, "R4 8-bit 55");
        send_char(9'h055, 1'b1, -1, 0);
        expect_char(9'h0A3, 1'b0, "R4 8-bit A3");
        send_char(9'h0A3, 1'b1, -1, 0);
        expect_char(9'h000, 1'b0, "R4 8-bit 00");
        send_char(9'h000, 1'b1, -1, 0);
        expect_char(9'h0FF, 1'b0, "R4 8-bit FF");
        send_char(9'h1FF, 1'b1, -1, 0);
        drain("R4 all 8-bit characters read");

        // R5: 9-bit characters
        nine_bit = 1'b1;
        expect_char(9'h1A5, 1'b0, "R5 9-bit 1A5");
        send_char(9'h1A5, 1'b1, -1, 0);
        expect_char(9'h0FF, 1'b0, "R5 9-bit 0FF");
        send_char(9'h0FF, 1'b1, -1, 0);
        nine_bit = 1'b0;
        drain("R5 all 9-bit characters read");

        // R6: low stop bit stores a framing error, then a good one clears it
        expect_char(9'h03C, 1'b1, "R6 framing error stored");
        send_char(9'h03C, 1'b0, -1, 0);
        expect_char(9'h0C3, 1'b0, "R6 framing error cleared");
        send_char(9'h0C3, 1'b1, -1, 0);
        drain("R6 characters read");

        // R2: short low pulse aborted silently at mid-bit check
        rx_line = 1'b0;
        repeat (5 * 4) @(negedge clk);
        rx_line = 1'b1;
        repeat (160) @(negedge clk);
        check(data_avail == 1'b0, "R2 false start gives no character", data_avail, 0);
        check(overrun == 1'b0, "R2 false start raises no flag", overrun, 0);
        expect_char(9'h081, 1'b0, "R2 character after false start");
        send_char(9'h081, 1'b1, -1, 0);
        drain("R2 character read");

        // R3: one flipped sample at tick 8 of data bits is outvoted
        expect_char(9'h05A, 1'b0, "R3 glitch in data bit 3");
        send_char(9'h05A, 1'b1, 4, 8);
        expect_char(9'h0A5, 1'b0, "R3 glitch in stop bit");
        send_char(9'h0A5, 1'b1, 9, 8);
        drain("R3 characters read");

        // R10: inverted line polarity
        line_invert = 1'b1;
        rx_line = 1'b0;
        repeat (64) @(negedge clk);
        expect_char(9'h0C6, 1'b0, "R10 inverted character");
        send_char(9'h0C6, 1'b1, -1, 0);
        drain("R10 character read");
        line_invert = 1'b0;
        rx_line = 1'b1;
        repeat (64) @(negedge clk);

        // R11: each disabling control blocks reception
        port_enable = 1'b0;
        send_char(9'h011, 1'b1, -1, 0);
        check(data_avail == 1'b0, "R11 port disabled", data_avail, 0);
        port_enable = 1'b1;
        sync_mode = 1'b1;
        send_char(9'h022, 1'b1, -1, 0);
        check(data_avail == 1'b0, "R11 sync mode", data_avail, 0);
        sync_mode = 1'b0;
        rx_enable = 1'b0;
        send_char(9'h033, 1'b1, -1, 0);
        check(data_avail == 1'b0, "R11 receiver disabled", data_avail, 0);
        rx_enable = 1'b1;
        repeat (64) @(negedge clk);

        // R8: third character overruns, fourth is ignored
        auto_read = 1'b0;
        expect_char(9'h0E1, 1'b0, "R7 oldest kept first");
        send_char(9'h0E1, 1'b1, -1, 0);
        expect_char(9'h01E, 1'b1, "R7 second kept in order");
        send_char(9'h01E, 1'b0, -1, 0);
        check(overrun == 1'b0, "R8 two entries do not overrun", overrun, 0);
        send_char(9'h077, 1'b1, -1, 0);
        check(overrun == 1'b1, "R8 overrun on third character", overrun, 1);
        send_char(9'h099, 1'b1, -1, 0);
        check(overrun == 1'b1, "R8 overrun holds", overrun, 1);
        check({rd_frame_err, rd_data} == 10'h0E1, "R8 head unchanged", {rd_frame_err, rd_data}, 10'h0E1);

        // R9: receiver disable clears overrun and keeps the buffer
        rx_enable = 1'b0;
        repeat (2) @(negedge clk);
        check(overrun == 1'b0, "R9 overrun cleared", overrun, 0);
        check(data_avail == 1'b1, "R9 buffer kept", data_avail, 1);
        rx_enable = 1'b1;
        auto_read = 1'b1;
        drain("R9 buffered characters read");
        check(data_avail == 1'b0, "R7 empty after reads", data_avail, 0);
        expect_char(9'h0B4, 1'b0, "R9 reception resumes");
        send_char(9'h0B4, 1'b1, -1, 0);
        drain("R9 character read");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule